// File: doc/BRIEF.md
# Self-Powering-Down Serial Sampler Interface

This block is the digital control side of a serial-output sampling converter that spends its idle time in a low-power state and wakes only for the length of one read frame. A falling chip select starts a frame: the front end leaves powerdown and the track-and-hold starts tracking. The third falling serial-clock edge puts the track-and-hold back into hold and captures the sample. The captured value is then shifted out MSB first behind four zero bits. On the last falling edge of the frame the block drops back into powerdown by itself. If chip select rises before that edge, the frame is abandoned.

The resolution is fixed at build time by a parameter. It is meant to be 12, 10 or 8 bits, which gives a frame of 16, 14 or 12 falling edges. Chip select and the serial clock are oversampled by the block's own clock, and each edge is acted on at the first rising clock edge that sees it. A parallel input stands in for the value that the analog front end would deliver. After reset the state is treated as unknown, and it stays so until one complete frame has been run. That first frame is a dummy, and it leaves the block in powerdown.

Top module: `apd_serial_adc`

## Requirements
- R1: After reset the block is in its unknown start-up state: `pdown_o`=0, `hold_o`=1, `sdata_oe_o`=0, `valid_o`=0.
- R2: A falling `cs_n` seen while idle sets `hold_o`=0 and `pdown_o`=0 and drives the output (`sdata_oe_o`=1), with `sdata_o`=0.
- R3: `hold_o` returns to 1 on the 3rd falling `sclk` edge after `cs_n` fell, and `sample_i` is captured on that edge.
- R4: On falling `sclk` edge number RES_BITS+4, the block enters powerdown: `pdown_o`=1 and `sdata_oe_o`=0.
- R5: After falling edge k of a frame (k counted from 0 at the `cs_n` fall), `sdata_o` is 0 for k<4. For 4≤k<RES_BITS+4 it is bit RES_BITS-1-(k-4) of the captured sample, so the MSB comes first.
- R6: If `cs_n` rises before the final edge, the frame is aborted. The output goes to high impedance (`sdata_oe_o`=0), no valid pulse is given, and the block enters powerdown once it has completed a frame since reset.
- R7: The first completed frame after reset is a dummy. It gives no `valid_o` pulse and ends with `pdown_o`=1. A frame aborted before that returns to the start-up state (`pdown_o`=0).
- R8: Every completed frame after the dummy pulses `valid_o` high for exactly one clock cycle.
- R9: Falling `sclk` edges while `cs_n` is high have no effect: the block stays in powerdown with the output not driven.
- R10: While a frame is active, `sdata_o` changes only in the cycle that acts on a falling `sclk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Active-low chip select; its fall starts a frame |
| sclk | input | 1 | Serial clock; idles high, its falling edges step the frame |
| sample_i | input | RES_BITS | Parallel value that stands in for the analog sample |
| sdata_o | output | 1 | Serial data bit |
| sdata_oe_o | output | 1 | Drive enable for the serial data; 0 means high impedance |
| hold_o | output | 1 | 1 while the track-and-hold is in hold |
| pdown_o | output | 1 | 1 while the block is in powerdown |
| valid_o | output | 1 | One-cycle pulse when a non-dummy frame completes |

## Verification
Each pin edge is registered once in the edge detector, and the state register updates on the same clock edge. Every output therefore reflects a `cs_n` or `sclk` transition one rising clock edge after the input changes. `valid_o` is high for that single cycle only. The bench changes its inputs on falling clock edges and samples on the next falling edge, which is half a cycle after the one rising edge that acts on the input. It then looks one cycle further to confirm that the valid pulse has ended. Reset release passes through two synchronizer flops, so the bench waits several cycles before it checks the start-up state.

// File: rtl/apd_pkg.sv
package apd_pkg;
  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_PDOWN = 2'd1,
    ST_TRACK = 2'd2,
    ST_CONV  = 2'd3
  } apd_state_e;

  localparam int LEAD_ZEROS = 4;
  localparam int HOLD_EDGE  = 3;
endpackage

// File: rtl/apd_edge_det.sv
module apd_edge_det #(
  parameter bit IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o,
  output logic rise_o
);
  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= IDLE;
    else        pin_q <= pin_i;
  end

  always_comb begin
    fall_o = pin_q & ~pin_i;
    rise_o = ~pin_q & pin_i;
  end
endmodule

// File: rtl/apd_seq_fsm.sv
module apd_seq_fsm
  import apd_pkg::*;
#(
  parameter int FRAME = 16,
  parameter int CNT_W = $clog2(FRAME)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             sclk_fall_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_o,
  output logic             capture_o,
  output logic             hold_o,
  output logic             pdown_o,
  output logic             valid_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0] HOLD_CNT = CNT_W'(HOLD_EDGE - 1);

  apd_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             primed_q, primed_d;
  logic             valid_q, valid_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    primed_d = primed_q;
    valid_d  = 1'b0;
    unique case (state_q)
      ST_INIT, ST_PDOWN: begin
        if (cs_fall_i) begin
          state_d = ST_TRACK;
          cnt_d   = '0;
        end
      end
      ST_TRACK, ST_CONV: begin
        if (cs_rise_i) begin
          state_d = primed_q ? ST_PDOWN : ST_INIT;
          cnt_d   = '0;
        end else if (sclk_fall_i) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == HOLD_CNT) state_d = ST_CONV;
          if (cnt_q == LAST_CNT) begin
            state_d  = ST_PDOWN;
            cnt_d    = '0;
            primed_d = 1'b1;
            valid_d  = primed_q;
          end
        end
      end
      default: state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_INIT;
      cnt_q    <= '0;
      primed_q <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      primed_q <= primed_d;
      valid_q  <= valid_d;
    end
  end

  always_comb begin
    active_o  = (state_q == ST_TRACK) || (state_q == ST_CONV);
    capture_o = active_o && !cs_rise_i && sclk_fall_i && (cnt_q == HOLD_CNT);
    hold_o    = (state_q != ST_TRACK);
    pdown_o   = (state_q == ST_PDOWN);
    valid_o   = valid_q;
    cnt_o     = cnt_q;
  end

  // R3: the capture edge puts the track-and-hold back into hold
  a_r3_hold_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture_o |=> hold_o && active_o);

  // R6: an abort leaves the frame without a valid pulse
  a_r6_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && cs_rise_i) |=> (!active_o && !valid_o));

  // R8: the valid pulse lasts one cycle
  a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R7: the start-up state never coexists with a valid pulse
  a_r7_init_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INIT) |-> !valid_o);
endmodule

// File: rtl/apd_sdo.sv
module apd_sdo
  import apd_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int CNT_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active_i,
  input  logic                capture_i,
  input  logic                sclk_fall_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic [RES_BITS-1:0] sample_i,
  output logic                sdata_o,
  output logic                sdata_oe_o
);
  localparam logic [CNT_W-1:0] DATA_START = CNT_W'(LEAD_ZEROS);

  logic [RES_BITS-1:0] shreg_q, shreg_d;
  logic                shift_en;

  always_comb begin
    shift_en = active_i && sclk_fall_i && (cnt_i >= DATA_START);
    shreg_d  = shreg_q;
    if (capture_i)     shreg_d = sample_i;
    else if (shift_en) shreg_d = {shreg_q[RES_BITS-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= '0;
    else        shreg_q <= shreg_d;
  end

  always_comb begin
    sdata_oe_o = active_i;
    sdata_o    = (active_i && (cnt_i >= DATA_START)) ? shreg_q[RES_BITS-1] : 1'b0;
  end

  // R10: within an active frame the data bit moves only after a falling sclk edge
  a_r10_bit_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !sclk_fall_i) |=> (!active_i || $stable(sdata_o)));
endmodule

// File: rtl/apd_serial_adc.sv
module apd_serial_adc
  import apd_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic [RES_BITS-1:0] sample_i,
  output logic                sdata_o,
  output logic                sdata_oe_o,
  output logic                hold_o,
  output logic                pdown_o,
  output logic                valid_o
);
  localparam int FRAME = RES_BITS + LEAD_ZEROS;
  localparam int CNT_W = $clog2(FRAME);

  logic             rst_meta_q, rst_sync_q;
  logic             cs_fall, cs_rise, sclk_fall, sclk_rise;
  logic [CNT_W-1:0] cnt;
  logic             active, capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  apd_edge_det #(.IDLE(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_sync_q), .pin_i(cs_n),
    .fall_o(cs_fall), .rise_o(cs_rise)
  );

  apd_edge_det #(.IDLE(1'b1)) u_sclk_edge (
    .clk(clk), .rst_n(rst_sync_q), .pin_i(sclk),
    .fall_o(sclk_fall), .rise_o(sclk_rise)
  );

  apd_seq_fsm #(.FRAME(FRAME), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_sync_q),
    .cs_fall_i(cs_fall), .cs_rise_i(cs_rise), .sclk_fall_i(sclk_fall),
    .cnt_o(cnt), .active_o(active), .capture_o(capture),
    .hold_o(hold_o), .pdown_o(pdown_o), .valid_o(valid_o)
  );

  apd_sdo #(.RES_BITS(RES_BITS), .CNT_W(CNT_W)) u_sdo (
    .clk(clk), .rst_n(rst_sync_q),
    .active_i(active), .capture_i(capture), .sclk_fall_i(sclk_fall),
    .cnt_i(cnt), .sample_i(sample_i),
    .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o)
  );

  // R4: powerdown and a driven output never coexist
  a_r4_pdown_floats: assert property (@(posedge clk) disable iff (!rst_sync_q)
    pdown_o |-> !sdata_oe_o);

  // R9: a falling sclk while chip select is high leaves powerdown unchanged
  a_r9_idle_sclk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (pdown_o && cs_n && !cs_fall && !cs_rise && (sclk_fall || sclk_rise)) |=> pdown_o);

  // R2: a frame in progress keeps the block out of powerdown
  a_r2_active_awake: assert property (@(posedge clk) disable iff (!rst_sync_q)
    sdata_oe_o |-> !pdown_o);
endmodule

// File: tb/apd_serial_adc_tb_top.sv
module apd_serial_adc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RES        = 12;
  localparam int FRAME      = RES + 4;

  logic           clk;
  logic           rst_n;
  logic           cs_n;
  logic           sclk;
  logic [RES-1:0] sample;
  logic           sdata, sdata_oe, hold, pdown, valid;

  int n_checks;
  int n_bad;
  bit finished;

  apd_serial_adc #(.RES_BITS(RES)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample_i(sample),
    .sdata_o(sdata), .sdata_oe_o(sdata_oe), .hold_o(hold),
    .pdown_o(pdown), .valid_o(valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic sclk_fall();
    sclk = 1'b1;
    step();
    sclk = 1'b0;
    step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; sample = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (5) step();
    chk(pdown == 1'b0, "R1 pdown", pdown, 0);
    chk(hold == 1'b1, "R1 hold", hold, 1);
    chk(sdata_oe == 1'b0, "R1 oe", sdata_oe, 0);
    chk(valid == 1'b0, "R1 valid", valid, 0);
  endtask

  task automatic t_abort_unprimed();
    cs_n = 1'b0; step();
    chk(sdata_oe == 1'b1, "R2 oe", sdata_oe, 1);
    chk(hold == 1'b0, "R2 hold", hold, 0);
    sclk_fall();
    cs_n = 1'b1; step();
    chk(pdown == 1'b0, "R7 abort before dummy stays unknown", pdown, 0);
    chk(sdata_oe == 1'b0, "R6 oe after abort", sdata_oe, 0);
    sclk = 1'b1; step();
  endtask

  task automatic t_frame(input logic [RES-1:0] val, input bit expect_valid, input string tag);
    int bad_bits;
    bad_bits = 0;
    sample = val;
    cs_n = 1'b0; step();
    chk(hold == 1'b0 && pdown == 1'b0 && sdata_oe == 1'b1 && sdata == 1'b0,
        {"R2 frame start ", tag}, {hold, pdown, sdata_oe, sdata}, 4'b0010);
    for (int k = 1; k < FRAME; k++) begin
      logic expb;
      sclk_fall();
      expb = (k < 4) ? 1'b0 : val[RES - 1 - (k - 4)];
      if (sdata !== expb || sdata_oe !== 1'b1) begin
        bad_bits++;
        $display("FAIL R5 %s edge %0d actual=%0b expected=%0b", tag, k, sdata, expb);
      end
      if (k == 2) chk(hold == 1'b0, {"R3 still tracking ", tag}, hold, 0);
      if (k == 3) chk(hold == 1'b1, {"R3 hold on third edge ", tag}, hold, 1);
      if (k == 4) sample = ~val;
    end
    chk(bad_bits == 0, {"R5 bit stream ", tag}, bad_bits, 0);
    sclk_fall();
    chk(pdown == 1'b1 && sdata_oe == 1'b0, {"R4 powerdown at final edge ", tag},
        {pdown, sdata_oe}, 2'b10);
    if (expect_valid) chk(valid == 1'b1, {"R8 valid pulse ", tag}, valid, 1);
    else              chk(valid == 1'b0, {"R7 dummy no valid ", tag}, valid, 0);
    step();
    chk(valid == 1'b0, {"R8 pulse ends ", tag}, valid, 0);
    cs_n = 1'b1; sclk = 1'b1; step(); step();
  endtask

  task automatic t_abort_primed(input int edges);
    int seen_valid;
    seen_valid = 0;
    cs_n = 1'b0; step();
    for (int k = 0; k < edges; k++) sclk_fall();
    cs_n = 1'b1; step();
    if (valid) seen_valid++;
    chk(pdown == 1'b1 && sdata_oe == 1'b0, "R6 abort to powerdown", {pdown, sdata_oe}, 2'b10);
    sclk = 1'b1; step();
    if (valid) seen_valid++;
    chk(seen_valid == 0, "R6 no valid on abort", seen_valid, 0);
  endtask

  task automatic t_idle_sclk();
    for (int k = 0; k < 20; k++) sclk_fall();
    sclk = 1'b1; step();
    chk(pdown == 1'b1 && sdata_oe == 1'b0 && valid == 1'b0, "R9 idle sclk ignored",
        {pdown, sdata_oe, valid}, 3'b100);
  endtask

  task automatic t_rise_only();
    int changes;
    logic prev;
    changes = 0;
    sample = 12'hFFF;
    cs_n = 1'b0; step();
    for (int k = 0; k < 5; k++) sclk_fall();
    prev = sdata;
    sclk = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step();
      if (sdata !== prev) changes++;
    end
    chk(changes == 0, "R10 no change on rising sclk", changes, 0);
    cs_n = 1'b1; step(); step();
  endtask

  initial begin
    n_checks = 0; n_bad = 0; finished = 1'b0;
    t_reset();
    t_abort_unprimed();
    t_frame(12'h5A3, 1'b0, "dummy");
    t_frame(12'hA5C, 1'b1, "alt");
    t_frame(12'hFFF, 1'b1, "ones");
    t_frame(12'h801, 1'b1, "ends");
    t_abort_primed(2);
    t_abort_primed(FRAME - 1);
    t_idle_sclk();
    t_rise_only();
    t_frame(12'h000, 1'b1, "zeros");
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end
endmodule